// File: doc/BRIEF.md
# Polled Serial and GPIO Register Slave

This block sits on the system bus of a small microcontroller. It maps a serial transmit port, a serial receive port and a GPIO port into one fixed address window. The bus is a single-cycle read/write bus. Read data is combinational on the address, so a bus master samples it in the same cycle that it presents the read. The serial side connects to byte-wide transmit and receive FIFOs through valid/ready streams. The FIFOs and the line-level serial engine live outside the block.

Software drives the serial side by polling. Before each transfer it checks a "transmit full" word and a "receive empty" word, each at its own address. A read of the receive data word consumes the byte it returns. The GPIO side has an output register and a per-bit direction register. A read of the value word merges the pin inputs on input bits with the output register on output bits.

Top module: `mmio_serial_gpio`

## Requirements
- R1: A write to window offset 0x00 while `tx_ready` is high raises `tx_valid` in that same cycle, with bits 7:0 of the write data on `tx_data`. Exactly one byte is handed over.
- R2: A write to offset 0x00 while `tx_ready` is low is dropped. `tx_valid` stays low, and no byte is delivered later.
- R3: A read of offset 0x04 returns 1 while `tx_ready` is low and 0 while it is high. All upper bits are zero.
- R4: A read of offset 0x08 while `rx_valid` is high returns `rx_data` in bits 7:0, with zeros above. It raises `rx_ready` in that cycle, which pops the byte, so each byte is returned once and in arrival order.
- R5: A read of offset 0x08 while `rx_valid` is low returns 0 and leaves `rx_ready` low.
- R6: A read of offset 0x0C returns 1 while `rx_valid` is low and 0 while it is high.
- R7: A write to offset 0x10 loads bits 15:0 of the write data into the GPIO output register, which drives `gpio_out` from the next cycle.
- R8: A write to offset 0x14 loads bits 15:0 into the direction register, which drives `gpio_oe` from the next cycle. A 1 bit marks an output, and writing 0xFFFF makes all pins outputs. A read of 0x14 returns the register.
- R9: A read of offset 0x10 returns `gpio_in` on bits whose direction is 0 and the output register on bits whose direction is 1.
- R10: Reads of any unmapped address return 0, and writes to such addresses change nothing. This covers offsets 0x18 and above, unaligned offsets, and addresses outside the window based at 0xE0000000.
- R11: After reset the output register and the direction register are both zero, so all pins are inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed to pop the receive byte) |
| bus_rdata | output | 32 | Combinational read data |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit path can accept a byte |
| rx_valid | input | 1 | Received byte waiting |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Pop the received byte |
| gpio_in | input | 16 | Pin input levels |
| gpio_out | output | 16 | Output register |
| gpio_oe | output | 16 | Per-pin output enable (direction) |

## Verification
The bench builds the block with its default parameters: a window at 0xE0000000 with 8 offset bits, 16 GPIO bits and 32-bit data. With these values the bench can reach unmapped offsets inside the window, such as 0x18 and an unaligned 0x02. It can also reach an address one window above the base (offset 0x110), which would alias the GPIO value word if the upper address bits were not decoded. The 16-bit GPIO width lets a single direction word split the port into an output half and an input half, so the merged read is checked on both halves at once.

// File: rtl/mmio_serial_gpio.sv
module mmio_serial_gpio #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_W  = 8,
  parameter int GPIO_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hE000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] gpio_out,
  output logic [GPIO_W-1:0] gpio_oe
);
  localparam logic [WIN_W-1:0] OFF_TXD  = WIN_W'('h00);
  localparam logic [WIN_W-1:0] OFF_TXF  = WIN_W'('h04);
  localparam logic [WIN_W-1:0] OFF_RXD  = WIN_W'('h08);
  localparam logic [WIN_W-1:0] OFF_RXE  = WIN_W'('h0C);
  localparam logic [WIN_W-1:0] OFF_GVAL = WIN_W'('h10);
  localparam logic [WIN_W-1:0] OFF_GDIR = WIN_W'('h14);

  logic             in_win;
  logic [WIN_W-1:0] off;
  logic [GPIO_W-1:0] gpio_rd;

  assign in_win = (bus_addr[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]);
  assign off    = bus_addr[WIN_W-1:0];

  assign tx_valid = bus_we && in_win && (off == OFF_TXD) && tx_ready;
  assign tx_data  = bus_wdata[BYTE_W-1:0];
  assign rx_ready = bus_re && in_win && (off == OFF_RXD) && rx_valid;
  assign gpio_rd  = (gpio_in & ~gpio_oe) | (gpio_out & gpio_oe);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpio_out <= '0;
      gpio_oe  <= '0;
    end else if (bus_we && in_win) begin
      if (off == OFF_GVAL) gpio_out <= bus_wdata[GPIO_W-1:0];
      if (off == OFF_GDIR) gpio_oe  <= bus_wdata[GPIO_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      case (off)
        OFF_TXF:  bus_rdata = {{(DATA_W-1){1'b0}}, ~tx_ready};
        OFF_RXD:  bus_rdata = rx_valid ? {{(DATA_W-BYTE_W){1'b0}}, rx_data} : '0;
        OFF_RXE:  bus_rdata = {{(DATA_W-1){1'b0}}, ~rx_valid};
        OFF_GVAL: bus_rdata = {{(DATA_W-GPIO_W){1'b0}}, gpio_rd};
        OFF_GDIR: bus_rdata = {{(DATA_W-GPIO_W){1'b0}}, gpio_oe};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_serial_gpio_chk.sv
module mmio_serial_gpio_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int GPIO_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'hE000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [GPIO_W-1:0] gpio_out,
  input logic [GPIO_W-1:0] gpio_oe
);
  assert_tx_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == BASE && tx_ready) |-> tx_valid);

  assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ready);

  assert_full_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == BASE + 32'h4) |-> (bus_rdata == {{(DATA_W-1){1'b0}}, !tx_ready}));

  assert_no_pop_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid);

  assert_dir_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == BASE + 32'h14) |=> (gpio_oe == $past(bus_wdata[GPIO_W-1:0])));

  assert_gpio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(gpio_out) && $stable(gpio_oe)));
endmodule

bind mmio_serial_gpio mmio_serial_gpio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GPIO_W(GPIO_W), .BASE(BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe)
);

// File: tb/mmio_serial_gpio_tb.sv
module mmio_serial_gpio_tb_top;
  localparam logic [31:0] B = 32'hE000_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1;
  logic [7:0]  tx_data;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready;
  logic [15:0] gpio_in = 0, gpio_out, gpio_oe;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0]  rx_q[$];
  logic [7:0]  tx_got[$];
  logic [15:0] m_out = 0, m_dir = 0;

  mmio_serial_gpio dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  task automatic rx_drive();
    rx_valid = rx_q.size() > 0;
    rx_data  = rx_q.size() > 0 ? rx_q[0] : 8'h00;
  endtask

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    if (a[31:8] != B[31:8]) return 0;
    case (a[7:0])
      8'h04: return {31'b0, !tx_ready};
      8'h08: return rx_q.size() > 0 ? {24'b0, rx_q[0]} : 0;
      8'h0C: return {31'b0, rx_q.size() == 0};
      8'h10: return {16'b0, (gpio_in & ~m_dir) | (m_out & m_dir)};
      8'h14: return {16'b0, m_dir};
      default: return 0;
    endcase
  endfunction

  // one bus cycle; entered just after a negedge
  task automatic op(input logic [31:0] a, input logic [31:0] d, input logic w, input logic r, input string tag);
    logic exp_tx, exp_pop;
    bus_addr = a; bus_wdata = d; bus_we = w; bus_re = r;
    rx_drive();
    #2;
    exp_tx  = w && a == B && tx_ready;
    exp_pop = r && a == B + 32'h8 && rx_q.size() > 0;
    if (r) chk(bus_rdata, model_rd(a), {tag, " rdata"});
    chk({31'b0, tx_valid}, {31'b0, exp_tx}, {tag, " tx_valid"});
    if (exp_tx) chk({24'b0, tx_data}, {24'b0, d[7:0]}, {tag, " tx_data"});
    chk({31'b0, rx_ready}, {31'b0, exp_pop}, {tag, " rx_ready"});
    @(posedge clk);
    if (tx_valid && tx_ready) tx_got.push_back(tx_data);
    if (exp_pop) void'(rx_q.pop_front());
    if (w && a == B + 32'h10) m_out = d[15:0];
    if (w && a == B + 32'h14) m_dir = d[15:0];
    @(negedge clk);
    bus_we = 0; bus_re = 0;
    rx_drive();
    chk({16'b0, gpio_out}, {16'b0, m_out}, {tag, " gpio_out"});
    chk({16'b0, gpio_oe}, {16'b0, m_dir}, {tag, " gpio_oe"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({16'b0, gpio_out}, 0, "R11 reset gpio_out");
    chk({16'b0, gpio_oe}, 0, "R11 reset gpio_oe");
    rst_n = 1;
    @(negedge clk);

    op(B + 32'hC, 0, 0, 1, "R6 empty flag set");
    op(B + 32'h8, 0, 0, 1, "R5 read empty rx");

    rx_q.push_back(8'h41); rx_q.push_back(8'h42);
    op(B + 32'hC, 0, 0, 1, "R6 empty flag clear");
    op(B + 32'h8, 0, 0, 1, "R4 first byte");
    op(B + 32'h8, 0, 0, 1, "R4 second byte");
    op(B + 32'hC, 0, 0, 1, "R4 queue drained");

    tx_ready = 1;
    op(B + 32'h4, 0, 0, 1, "R3 not full");
    op(B, 32'h1234_5655, 1, 0, "R1 push");
    chk(tx_got.size(), 1, "R1 one byte delivered");
    if (tx_got.size() > 0) chk({24'b0, tx_got[0]}, 32'h55, "R1 byte value");
    tx_ready = 0;
    op(B + 32'h4, 0, 0, 1, "R3 full");
    op(B, 32'hAA, 1, 0, "R2 write while full");
    tx_ready = 1;
    op(B + 32'h4, 0, 0, 1, "R3 not full again");
    chk(tx_got.size(), 1, "R2 dropped byte absent");

    op(B + 32'h14, 32'h0000_FFFF, 1, 0, "R8 all outputs");
    op(B + 32'h14, 0, 0, 1, "R8 read dir");
    op(B + 32'h10, 32'hFFFF_A5C3, 1, 0, "R7 write value");
    gpio_in = 16'h3C5A;
    op(B + 32'h10, 0, 0, 1, "R7 read back outputs");
    op(B + 32'h14, 32'h0000_00FF, 1, 0, "R8 low half outputs");
    op(B + 32'h10, 0, 0, 1, "R9 merged read");
    op(B + 32'h14, 0, 1, 0, "R9 all inputs");
    gpio_in = 16'h9E01;
    op(B + 32'h10, 0, 0, 1, "R9 inputs only");

    op(B + 32'h18, 32'hFFFF_FFFF, 1, 0, "R10 write 0x18");
    op(B + 32'h110, 32'hFFFF_FFFF, 1, 0, "R10 write outside window");
    op(B + 32'h12, 32'hFFFF_FFFF, 1, 0, "R10 write unaligned");
    op(B + 32'h18, 0, 0, 1, "R10 read 0x18");
    op(B + 32'h2, 0, 0, 1, "R10 read unaligned");
    op(B + 32'h114, 0, 0, 1, "R10 read outside window");
    rx_q.push_back(8'h77);
    op(B + 32'h108, 0, 0, 1, "R10 aliased rx read no pop");
    op(B + 32'h8, 0, 0, 1, "R4 byte after alias");
    op(B, 32'h0F, 1, 0, "R1 second push");
    chk(tx_got.size(), 2, "R1 second byte delivered");

    finish_run();
  end
endmodule